// File: doc/BRIEF.md
# Synchronized Multi-Ratio Clock Divider

This block produces three divided clocks (core, I/O and system) and a feedback clock for the PLL from one fast oscillator clock. Each output has its own counter. The counter runs on the oscillator clock, and a comparison against the active ratio decides when the output is high and when it is low. The feedback divider runs at a fixed ratio. Each time it wraps, it clears the other counters, so every output stays phase-aligned to it.

Software asks for new ratios from the slower reference clock domain. The request is taken on the falling edge of the reference clock and passed to the oscillator domain with a toggle handshake. A shadow register there loads only when the requested ratios differ from the ones it already holds. The pending ratios become active one oscillator cycle before the next rising edge of the feedback divider. All outputs therefore take their new period on the same edge, and no output has a cut-short phase. A one-cycle flag in the reference domain reports that the new ratios are in effect.

Top module: `clkdiv_sync_top`

## Requirements
- R1: While reset is asserted, every clock output and `change_done` are low. After reset, the active ratios are the parameters `CORE_INIT`, `IO_INIT` and `SYS_INIT`.
- R2: An output running at ratio N has a period of N oscillator cycles. It is high for N - floor(N/2) cycles and low for floor(N/2) cycles, starting high at each period boundary.
- R3: A requested ratio of 0 or 1 is treated as 2.
- R4: A request is sampled on the falling edge of `ref_clk` in which `req_valid` is high. The three ratio inputs are sampled together.
- R5: New ratios become active in the oscillator cycle just before a rising edge of the feedback clock. At every rising edge of the feedback clock, all three outputs rise on the same oscillator edge.
- R6: During a ratio change, no high or low phase of any output is shorter than floor(min(old, new)/2) oscillator cycles.
- R7: The feedback clock keeps a period of `FB_RATIO` oscillator cycles at all times, whatever ratios are requested.
- R8: Once requested ratios become active, `change_done` is high for exactly one `ref_clk` cycle.
- R9: A request whose clamped ratios equal the ratios already held causes no change and no `change_done` pulse.
- R10: A request that arrives while an earlier change is still pending replaces it. The outputs end up at the latest ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock that all dividers count |
| ref_clk | input | 1 | Reference clock; requests are taken on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| req_valid | input | 1 | Ratio-change request strobe, reference domain |
| req_core_ratio | input | 8 | Requested core divide ratio |
| req_io_ratio | input | 8 | Requested I/O divide ratio |
| req_sys_ratio | input | 8 | Requested system divide ratio |
| core_clk_o | output | 1 | Divided core clock |
| io_clk_o | output | 1 | Divided I/O clock |
| sys_clk_o | output | 1 | Divided system clock |
| fb_clk_o | output | 1 | Fixed-ratio feedback clock for the PLL |
| change_done | output | 1 | One reference-cycle pulse once new ratios are active |

## Verification
The alignment check and the phase checks assume three things. Every active ratio divides `FB_RATIO`. The oscillator runs many times faster than the reference clock. Successive applications of new ratios are at least two reference cycles apart, which holds when the feedback period is longer than two reference periods. The stimulus meets all three: the feedback ratio is 48, the ratios are drawn only from divisors of 48, and the reference clock is twenty times slower than the oscillator. Requests are driven just after a rising reference edge, so they are stable at the falling edge that samples them.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned RATIO_W = 8;
  localparam int unsigned NUM_DOM = 3;

  typedef logic [RATIO_W-1:0] ratio_t;

  typedef enum int unsigned {
    DOM_CORE = 0,
    DOM_IO   = 1,
    DOM_SYS  = 2
  } dom_e;

  // Smallest ratio that still gives a toggling output.
  localparam ratio_t MIN_RATIO = ratio_t'(2);
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;
endmodule

// File: rtl/clkdiv_req_capture.sv
module clkdiv_req_capture
  import clkdiv_pkg::*;
(
  input  logic   ref_clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  ratio_t req_ratio_i [NUM_DOM],
  output ratio_t cap_ratio_o [NUM_DOM],
  output logic   cap_tog_o
);
  ratio_t cap_q [NUM_DOM];
  ratio_t cap_d [NUM_DOM];
  logic   tog_q;
  logic   tog_d;

  always_comb begin
    tog_d = tog_q ^ req_valid;
    for (int d = 0; d < NUM_DOM; d++) begin
      cap_d[d] = req_valid ? req_ratio_i[d] : cap_q[d];
    end
  end

  // Requests are sampled on the falling reference edge.
  always_ff @(negedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      for (int d = 0; d < NUM_DOM; d++) cap_q[d] <= MIN_RATIO;
    end else begin
      tog_q <= tog_d;
      for (int d = 0; d < NUM_DOM; d++) cap_q[d] <= cap_d[d];
    end
  end

  assign cap_ratio_o = cap_q;
  assign cap_tog_o   = tog_q;
endmodule

// File: rtl/clkdiv_ratio_xfer.sv
module clkdiv_ratio_xfer
  import clkdiv_pkg::*;
#(
  parameter int unsigned CORE_INIT = 2,
  parameter int unsigned IO_INIT   = 4,
  parameter int unsigned SYS_INIT  = 8
) (
  input  logic   osc_clk,
  input  logic   rst_n,
  input  ratio_t cap_ratio_i [NUM_DOM],
  input  logic   cap_tog_i,
  input  logic   pre_sync_i,
  output ratio_t act_ratio_o [NUM_DOM],
  output logic   apply_o,
  output logic   done_tog_o
);
  localparam ratio_t INIT_R [NUM_DOM] = '{ratio_t'(CORE_INIT), ratio_t'(IO_INIT), ratio_t'(SYS_INIT)};

  logic   tog_s1_q, tog_s2_q, tog_s3_q;
  ratio_t clamped   [NUM_DOM];
  ratio_t shadow_q  [NUM_DOM];
  ratio_t shadow_d  [NUM_DOM];
  ratio_t act_q     [NUM_DOM];
  ratio_t act_d     [NUM_DOM];
  logic   pend_q, pend_d;
  logic   done_tog_q, done_tog_d;
  logic   tog_evt, differs, load_en, apply;

  always_comb begin
    tog_evt = tog_s2_q ^ tog_s3_q;
    differs = 1'b0;
    for (int d = 0; d < NUM_DOM; d++) begin
      clamped[d] = (cap_ratio_i[d] < MIN_RATIO) ? MIN_RATIO : cap_ratio_i[d];
      if (clamped[d] != shadow_q[d]) differs = 1'b1;
    end
    // Shadow loads for one cycle only when its content would change.
    load_en    = tog_evt & differs;
    apply      = pend_q & pre_sync_i;
    pend_d     = load_en | (pend_q & ~apply);
    done_tog_d = done_tog_q ^ apply;
    for (int d = 0; d < NUM_DOM; d++) begin
      shadow_d[d] = load_en ? clamped[d] : shadow_q[d];
      act_d[d]    = apply ? shadow_q[d] : act_q[d];
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_s1_q   <= 1'b0;
      tog_s2_q   <= 1'b0;
      tog_s3_q   <= 1'b0;
      pend_q     <= 1'b0;
      done_tog_q <= 1'b0;
      for (int d = 0; d < NUM_DOM; d++) begin
        shadow_q[d] <= INIT_R[d];
        act_q[d]    <= INIT_R[d];
      end
    end else begin
      tog_s1_q   <= cap_tog_i;
      tog_s2_q   <= tog_s1_q;
      tog_s3_q   <= tog_s2_q;
      pend_q     <= pend_d;
      done_tog_q <= done_tog_d;
      for (int d = 0; d < NUM_DOM; d++) begin
        shadow_q[d] <= shadow_d[d];
        act_q[d]    <= act_d[d];
      end
    end
  end

  assign act_ratio_o = act_q;
  assign apply_o     = apply;
  assign done_tog_o  = done_tog_q;
endmodule

// File: rtl/clkdiv_divider.sv
module clkdiv_divider
  import clkdiv_pkg::*;
(
  input  logic   osc_clk,
  input  logic   rst_n,
  input  logic   sync_i,
  input  ratio_t ratio_i,
  output logic   clk_o
);
  ratio_t cnt_q, cnt_d;
  ratio_t high_len;
  logic   out_q, out_d;
  logic   at_last;

  always_comb begin
    high_len = ratio_i - (ratio_i >> 1);
    at_last  = (cnt_q >= (ratio_i - ratio_t'(1)));
    // The feedback wrap restarts this counter so its edges stay aligned.
    if (sync_i || at_last) cnt_d = '0;
    else                   cnt_d = cnt_q + ratio_t'(1);
    out_d = (cnt_d < high_len);
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign clk_o = out_q;
endmodule

// File: rtl/clkdiv_done_pulse.sv
module clkdiv_done_pulse (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic done_tog_i,
  output logic done_o
);
  logic s1_q, s2_q, s3_q, done_q;
  logic done_d;

  assign done_d = s2_q ^ s3_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      s1_q   <= done_tog_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/clkdiv_sync_top.sv
module clkdiv_sync_top
  import clkdiv_pkg::*;
#(
  parameter int unsigned FB_RATIO  = 24,
  parameter int unsigned CORE_INIT = 2,
  parameter int unsigned IO_INIT   = 4,
  parameter int unsigned SYS_INIT  = 8
) (
  input  logic       osc_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_core_ratio,
  input  logic [7:0] req_io_ratio,
  input  logic [7:0] req_sys_ratio,
  output logic       core_clk_o,
  output logic       io_clk_o,
  output logic       sys_clk_o,
  output logic       fb_clk_o,
  output logic       change_done
);
  localparam ratio_t FB_R    = ratio_t'(FB_RATIO);
  localparam ratio_t FB_HIGH = ratio_t'(FB_RATIO - FB_RATIO / 2);

  logic   osc_rst_n, ref_rst_n;
  ratio_t req_arr [NUM_DOM];
  ratio_t cap_arr [NUM_DOM];
  ratio_t act_arr [NUM_DOM];
  logic   cap_tog, done_tog, apply_w;
  logic   sync_w, pre_sync_w;
  ratio_t fb_cnt_q, fb_cnt_d;
  logic   fb_out_q, fb_out_d;
  logic   div_clk [NUM_DOM];

  clkdiv_rst_sync u_osc_rst (.clk(osc_clk), .arst_n(rst_n), .rst_n_o(osc_rst_n));
  clkdiv_rst_sync u_ref_rst (.clk(ref_clk), .arst_n(rst_n), .rst_n_o(ref_rst_n));

  assign req_arr[DOM_CORE] = req_core_ratio;
  assign req_arr[DOM_IO]   = req_io_ratio;
  assign req_arr[DOM_SYS]  = req_sys_ratio;

  clkdiv_req_capture u_capture (
    .ref_clk     (ref_clk),
    .rst_n       (ref_rst_n),
    .req_valid   (req_valid),
    .req_ratio_i (req_arr),
    .cap_ratio_o (cap_arr),
    .cap_tog_o   (cap_tog)
  );

  clkdiv_ratio_xfer #(
    .CORE_INIT (CORE_INIT),
    .IO_INIT   (IO_INIT),
    .SYS_INIT  (SYS_INIT)
  ) u_xfer (
    .osc_clk     (osc_clk),
    .rst_n       (osc_rst_n),
    .cap_ratio_i (cap_arr),
    .cap_tog_i   (cap_tog),
    .pre_sync_i  (pre_sync_w),
    .act_ratio_o (act_arr),
    .apply_o     (apply_w),
    .done_tog_o  (done_tog)
  );

  // Feedback divider: fixed ratio, never touched by requests.
  // Its counter leaves reset on the last count, so the first edge is a common one.
  assign sync_w     = (fb_cnt_q == FB_R - ratio_t'(1));
  assign pre_sync_w = (fb_cnt_q == FB_R - ratio_t'(2));

  always_comb begin
    fb_cnt_d = sync_w ? '0 : fb_cnt_q + ratio_t'(1);
    fb_out_d = (fb_cnt_d < FB_HIGH);
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      fb_cnt_q <= FB_R - ratio_t'(1);
      fb_out_q <= 1'b0;
    end else begin
      fb_cnt_q <= fb_cnt_d;
      fb_out_q <= fb_out_d;
    end
  end

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_div
    clkdiv_divider u_div (
      .osc_clk (osc_clk),
      .rst_n   (osc_rst_n),
      .sync_i  (sync_w),
      .ratio_i (act_arr[g]),
      .clk_o   (div_clk[g])
    );
  end

  clkdiv_done_pulse u_done (
    .ref_clk    (ref_clk),
    .rst_n      (ref_rst_n),
    .done_tog_i (done_tog),
    .done_o     (change_done)
  );

  assign core_clk_o = div_clk[DOM_CORE];
  assign io_clk_o   = div_clk[DOM_IO];
  assign sys_clk_o  = div_clk[DOM_SYS];
  assign fb_clk_o   = fb_out_q;
endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk #(
  parameter int unsigned FB_RATIO = 24
) (
  input logic osc_clk,
  input logic ref_clk,
  input logic rst_n,
  input logic core_clk_o,
  input logic io_clk_o,
  input logic sys_clk_o,
  input logic fb_clk_o,
  input logic change_done,
  input logic sync_w,
  input logic apply_w
);
  logic        fb_prev_q;
  logic        seen_q;
  logic [15:0] gap_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_prev_q <= 1'b0;
      seen_q    <= 1'b0;
      gap_q     <= '0;
    end else begin
      fb_prev_q <= fb_clk_o;
      if (fb_clk_o && !fb_prev_q) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else begin
        gap_q <= gap_q + 16'd1;
      end
    end
  end

  AST_ALIGNED_RISE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(fb_clk_o) |-> ($rose(core_clk_o) && $rose(io_clk_o) && $rose(sys_clk_o))); // R5

  AST_LOAD_BEFORE_EDGE: assert property (@(posedge osc_clk) disable iff (!rst_n)
    apply_w |=> sync_w); // R5

  AST_FB_PERIOD_FIXED: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (seen_q && fb_clk_o && !fb_prev_q) |-> (gap_q == 16'(FB_RATIO - 1))); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    change_done |=> !change_done); // R8
endmodule

bind clkdiv_sync_top clkdiv_sync_chk #(.FB_RATIO(FB_RATIO)) u_chk (
  .osc_clk     (osc_clk),
  .ref_clk     (ref_clk),
  .rst_n       (rst_n),
  .core_clk_o  (core_clk_o),
  .io_clk_o    (io_clk_o),
  .sys_clk_o   (sys_clk_o),
  .fb_clk_o    (fb_clk_o),
  .change_done (change_done),
  .sync_w      (sync_w),
  .apply_w     (apply_w)
);

// File: tb/clkdiv_sync_top_bench.sv
module clkdiv_sync_top_bench;
  localparam int OSC_PERIOD = 2;
  localparam int REF_PERIOD = 40;
  localparam int FB = 48;
  localparam int NV = 6;
  // {req core, req io, req sys, exp core, exp io, exp sys}
  localparam int VEC [NV][6] = '{
    '{ 4,  8, 16,  4,  8, 16},
    '{ 2,  3,  6,  2,  3,  6},
    '{ 0,  1, 48,  2,  2, 48},
    '{16, 24, 12, 16, 24, 12},
    '{ 6,  2,  4,  6,  2,  4},
    '{48, 16,  3, 48, 16,  3}
  };

  logic osc_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [7:0] req_core, req_io, req_sys;
  logic core_clk, io_clk, sys_clk, fb_clk, change_done;
  logic [2:0] outs;

  int total = 0;
  int bad = 0;
  int cur_eff [3];
  int min_ph [3];
  int run_len [3];
  bit armed [3];
  logic [2:0] mon_prev;
  logic mon_fb_prev;
  bit mon_en = 0;
  int short_err = 0;
  int align_err = 0;

  always #(OSC_PERIOD/2) osc_clk = ~osc_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  clkdiv_sync_top #(.FB_RATIO(FB), .CORE_INIT(2), .IO_INIT(4), .SYS_INIT(8)) u_clkdiv_sync_top (
    .osc_clk(osc_clk), .ref_clk(ref_clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_core_ratio(req_core), .req_io_ratio(req_io), .req_sys_ratio(req_sys),
    .core_clk_o(core_clk), .io_clk_o(io_clk), .sys_clk_o(sys_clk), .fb_clk_o(fb_clk),
    .change_done(change_done)
  );

  assign outs = {sys_clk, io_clk, core_clk};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Phase-length and alignment monitor, sampled on the falling oscillator edge.
  always @(negedge osc_clk) begin
    if (mon_en) begin
      for (int d = 0; d < 3; d++) begin
        if (outs[d] == mon_prev[d]) run_len[d]++;
        else begin
          if (armed[d] && run_len[d] < min_ph[d]) short_err++;
          armed[d] = 1'b1;
          run_len[d] = 1;
        end
      end
      if (fb_clk && !mon_fb_prev && (outs != 3'b111 || mon_prev != 3'b000)) align_err++;
    end
    mon_prev = outs;
    mon_fb_prev = fb_clk;
  end

  task automatic send(input int c, input int i, input int s);
    @(posedge ref_clk); #1;
    req_valid = 1'b1; req_core = 8'(c); req_io = 8'(i); req_sys = 8'(s);
    @(posedge ref_clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic count_done(input int cycles, output int n);
    n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge ref_clk);
      if (change_done) n++;
    end
  endtask

  // Measures one feedback period starting at a feedback rise (R2, R7).
  task automatic measure(input int ec, input int ei, input int es, input string tag);
    int exp_r [3];
    int rises [3];
    int highs [3];
    logic [2:0] p;
    logic fp;
    bit found;
    exp_r[0] = ec; exp_r[1] = ei; exp_r[2] = es;
    p = outs; fp = fb_clk; found = 0;
    for (int k = 0; k < 400 && !found; k++) begin
      @(negedge osc_clk);
      if (fb_clk && !fp) found = 1;
      else begin p = outs; fp = fb_clk; end
    end
    check(found, {tag, " R7 fb edge seen"}, found, 1);
    for (int d = 0; d < 3; d++) begin rises[d] = 0; highs[d] = 0; end
    for (int k = 0; k < FB; k++) begin
      if (k > 0) @(negedge osc_clk);
      for (int d = 0; d < 3; d++) begin
        if (outs[d] && !p[d]) rises[d]++;
        if (outs[d]) highs[d]++;
      end
      p = outs;
    end
    @(negedge osc_clk);
    check(fb_clk && !p[0] == !p[0] && fb_clk, {tag, " R7 fb period"}, fb_clk, 1);
    for (int d = 0; d < 3; d++) begin
      check(rises[d] == FB / exp_r[d], {tag, " R2 rises per fb period"}, rises[d], FB / exp_r[d]);
      check(highs[d] == (FB / exp_r[d]) * (exp_r[d] - exp_r[d] / 2), {tag, " R2 high cycles"},
            highs[d], (FB / exp_r[d]) * (exp_r[d] - exp_r[d] / 2));
    end
    check(short_err == 0, {tag, " R6 no short phase"}, short_err, 0);
    check(align_err == 0, {tag, " R5 aligned rise"}, align_err, 0);
  endtask

  initial begin
    #(OSC_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog (whole run) act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_core = '0; req_io = '0; req_sys = '0;
    cur_eff[0] = 2; cur_eff[1] = 4; cur_eff[2] = 8;
    for (int d = 0; d < 3; d++) begin min_ph[d] = cur_eff[d] / 2; run_len[d] = 0; armed[d] = 0; end
    repeat (5) @(negedge osc_clk);
    check(outs == 3'b000 && !fb_clk, "R1 outputs low in reset", int'({fb_clk, outs}), 0);
    check(!change_done, "R1 done low in reset", change_done, 0);
    @(negedge ref_clk); rst_n = 1'b1;
    mon_en = 1;
    measure(2, 4, 8, "R1 init ratios");

    // Table walk: R4 request sampled on falling ref edge, R3 clamp in vector 2.
    for (int v = 0; v < NV; v++) begin
      for (int d = 0; d < 3; d++) min_ph[d] = imin(cur_eff[d], VEC[v][3+d]) / 2;
      send(VEC[v][0], VEC[v][1], VEC[v][2]);
      count_done(12, n);
      check(n == 1, $sformatf("R8 done pulse vec%0d", v), n, 1);
      measure(VEC[v][3], VEC[v][4], VEC[v][5], $sformatf("R4 R3 vec%0d", v));
      for (int d = 0; d < 3; d++) begin cur_eff[d] = VEC[v][3+d]; min_ph[d] = cur_eff[d] / 2; end
    end

    // R9: repeat of the settings already held.
    send(48, 16, 3);
    count_done(12, n);
    check(n == 0, "R9 no done on same ratios", n, 0);
    measure(48, 16, 3, "R9 unchanged");

    // R10: second request one reference cycle behind the first.
    min_ph[0] = imin(48, imin(4, 8)) / 2;
    min_ph[1] = imin(16, imin(4, 6)) / 2;
    min_ph[2] = imin(3, imin(4, 12)) / 2;
    send(4, 4, 4);
    send(8, 6, 12);
    count_done(16, n);
    check(n >= 1, "R10 done after replaced request", n, 1);
    measure(8, 6, 12, "R10 latest wins");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule